// File: doc/BRIEF.md
# Forward Channel Sync Status Tracker

This block keeps the receive-side channel state of a cellular packet data forward channel. Upstream logic gives it a strobe for each received bit and a one-cycle pulse when the sync word has been found, together with the colour code byte that arrived with that sync word. It also receives the busy/idle bits with a marker on the last bit of each five-bit group, and decode success/failure reports from the base station. The block keeps a status byte: a sync flag, a decode-failure flag and an idle flag. It also holds a colour code register and two sticky interrupt flags, one for sync events and one for idle updates.

The sync flag sets on each detection and drops once more than a fixed number of bit periods pass with no detection. The idle flag is a majority vote over the most recent five-bit busy/idle group. It and the decode flag can change only while sync is held. A host reads the three registers through a simple combinational read port. Reading the flag register clears the flags, and `irq` is high while either flag is set.

Top module: `fwd_sync_tracker`

## Requirements
- R1: The cycle after `sync_det` is high, status bit 7 (SYNC) reads 1.
- R2: Each `bit_stb` without `sync_det` advances a loss counter that restarts at every detection. SYNC still reads 1 after 420 such strobes and reads 0 after the 421st.
- R3: The idle value of a group is 1 when at least three of its five busy/idle bits are 1, and 0 otherwise.
- R4: While SYNC is 0, status bits 6 (DEC) and 5 (IDLE) keep their values across decode reports and completed groups. The only exception is the acquisition publish of R6.
- R5: A group that completes (`bi_vld` and `bi_last` high) while SYNC is 1 writes its vote to IDLE in the next cycle and sets IDLEF (flag bit 1).
- R6: A group completed before any sync never reaches IDLE. When sync is acquired (`sync_det` while SYNC is 0), the vote of the most recently completed group is written to IDLE and IDLEF is set.
- R7: A decode report (`dec_vld`) taken while SYNC is 1 loads `dec_fail` into DEC: 1 for a failure, 0 for a success.
- R8: The colour code register (address 1, bit 7 the MSB) loads `cc_in` only on `sync_det`, and SYNCF (flag bit 0) sets in the same cycle. At all other times the register holds.
- R9: Address 0 reads status and address 2 reads the flags. A read of address 2 with `rd_en` high clears both flags on the next edge. `irq` is 1 exactly while a flag is set.
- R10: Status bits 4 to 0 always read 0, and address 3 reads 0.
- R11: A flag whose event occurs in the same cycle as a clearing read stays set.
- R12: After a synchronous reset, every register, flag and `irq` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_stb | input | 1 | One pulse per received bit period |
| sync_det | input | 1 | Sync word found (one-cycle pulse) |
| cc_in | input | 8 | Colour code received with the sync word |
| bi_vld | input | 1 | Busy/idle bit valid |
| bi_bit | input | 1 | Busy/idle bit, 1 = idle |
| bi_last | input | 1 | Marks the fifth bit of a group |
| dec_vld | input | 1 | Decode report valid |
| dec_fail | input | 1 | Decode report, 1 = failure |
| rd_en | input | 1 | Read strobe (clears flags at address 2) |
| rd_addr | input | 2 | Register address |
| rd_data | output | 8 | Read data |
| irq | output | 1 | Any interrupt flag set |

## Verification
The assertions take for granted that `bi_last` arrives only with `bi_vld` and only on every fifth valid bit, so the shift register always holds one aligned group. They also assume that `sync_det` is a single-cycle pulse. The bench drives busy/idle bits only through a five-bit group task and pulses sync for exactly one cycle. It runs the counter past the threshold only with plain strobes. It then checks holding, acquisition publishing and the read/set race at the ports.

// File: rtl/fst_pkg.sv
package fst_pkg;
    localparam int STAT_SYNC_BIT = 7;
    localparam int STAT_DEC_BIT  = 6;
    localparam int STAT_IDLE_BIT = 5;

    localparam int FLAG_SYNC = 0;
    localparam int FLAG_IDLE = 1;
    localparam int NUM_FLAGS = 2;

    localparam logic [1:0] ADDR_STATUS = 2'd0;
    localparam logic [1:0] ADDR_COLOUR = 2'd1;
    localparam logic [1:0] ADDR_FLAGS  = 2'd2;
endpackage

// File: rtl/fst_sync_timer.sv
module fst_sync_timer #(
    parameter int LOST_BITS = 420
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_stb,
    input  logic sync_det,
    output logic sync_o
);
    localparam int CNT_W = $clog2(LOST_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOST_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(LOST_BITS + 1);

    typedef struct packed {
        logic             sync;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sync_det) begin
            st_d.sync = 1'b1;
            st_d.cnt  = '0;
        end else if (bit_stb) begin
            if (st_q.cnt != CNT_SAT) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (st_q.cnt == CNT_LAST) begin
                st_d.sync = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.sync;

    a_r1_sync_sets: assert property (@(posedge clk) disable iff (rst)
        sync_det |=> st_q.sync);

    a_r2_no_early_loss: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.sync) |-> ($past(bit_stb) && $past(st_q.cnt) == CNT_LAST));

    a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= CNT_SAT);
endmodule

// File: rtl/fst_idle_vote.sv
module fst_idle_vote #(
    parameter int GRP_BITS = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic bi_vld,
    input  logic bi_bit,
    input  logic bi_last,
    output logic grp_done_o,
    output logic grp_vote_o,
    output logic last_vote_o,
    output logic have_grp_o
);
    localparam int MAJ = GRP_BITS / 2 + 1;

    typedef struct packed {
        logic [GRP_BITS-1:0] sr;
        logic                vote;
        logic                have;
    } vote_t;

    vote_t st_d, st_q;
    logic [GRP_BITS-1:0] sr_next;
    logic                vote_now;

    always_comb begin
        st_d     = st_q;
        sr_next  = {st_q.sr[GRP_BITS-2:0], bi_bit};
        vote_now = ($countones(sr_next) >= MAJ);
        if (bi_vld) begin
            st_d.sr = sr_next;
            if (bi_last) begin
                st_d.vote = vote_now;
                st_d.have = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grp_done_o  = bi_vld && bi_last;
    assign grp_vote_o  = vote_now;
    assign last_vote_o = st_q.vote;
    assign have_grp_o  = st_q.have;

    a_r6_have_sticky: assert property (@(posedge clk) disable iff (rst)
        st_q.have |=> st_q.have);

    a_r3_vote_held: assert property (@(posedge clk) disable iff (rst)
        !(bi_vld && bi_last) |=> $stable(st_q.vote));
endmodule

// File: rtl/fst_irq_flags.sv
module fst_irq_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flags_o
);
    typedef struct packed {
        logic [N-1:0] flg;
    } flg_t;

    flg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (set_i[i]) begin
                st_d.flg[i] = 1'b1;
            end else if (clr_i) begin
                st_d.flg[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flg;

    for (genvar g = 0; g < N; g++) begin : g_chk
        a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
            set_i[g] |=> st_q.flg[g]);
        a_r9_clear: assert property (@(posedge clk) disable iff (rst)
            (clr_i && !set_i[g]) |=> !st_q.flg[g]);
        a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
            (st_q.flg[g] && !clr_i) |=> st_q.flg[g]);
    end
endmodule

// File: rtl/fwd_sync_tracker.sv
module fwd_sync_tracker #(
    parameter int LOST_BITS = 420,
    parameter int GRP_BITS  = 5,
    parameter int CC_W      = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bit_stb,
    input  logic            sync_det,
    input  logic [CC_W-1:0] cc_in,
    input  logic            bi_vld,
    input  logic            bi_bit,
    input  logic            bi_last,
    input  logic            dec_vld,
    input  logic            dec_fail,
    input  logic            rd_en,
    input  logic [1:0]      rd_addr,
    output logic [7:0]      rd_data,
    output logic            irq
);
    import fst_pkg::*;

    typedef struct packed {
        logic [CC_W-1:0] cc;
        logic            dec;
        logic            idle;
    } top_t;

    top_t st_d, st_q;

    logic sync_q;
    logic grp_done, grp_vote, last_vote, have_grp;
    logic pub_grp, pub_acq;
    logic [NUM_FLAGS-1:0] flag_set, flags_q;
    logic flag_clr;
    logic [7:0] status;

    fst_sync_timer #(.LOST_BITS(LOST_BITS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .bit_stb  (bit_stb),
        .sync_det (sync_det),
        .sync_o   (sync_q)
    );

    fst_idle_vote #(.GRP_BITS(GRP_BITS)) u_vote (
        .clk         (clk),
        .rst         (rst),
        .bi_vld      (bi_vld),
        .bi_bit      (bi_bit),
        .bi_last     (bi_last),
        .grp_done_o  (grp_done),
        .grp_vote_o  (grp_vote),
        .last_vote_o (last_vote),
        .have_grp_o  (have_grp)
    );

    always_comb begin
        st_d    = st_q;
        pub_grp = grp_done && (sync_q || sync_det);
        pub_acq = sync_det && !sync_q && have_grp && !grp_done;
        if (sync_det) begin
            st_d.cc = cc_in;
        end
        if (dec_vld && sync_q) begin
            st_d.dec = dec_fail;
        end
        if (pub_grp) begin
            st_d.idle = grp_vote;
        end else if (pub_acq) begin
            st_d.idle = last_vote;
        end
        flag_set            = '0;
        flag_set[FLAG_SYNC] = sync_det;
        flag_set[FLAG_IDLE] = pub_grp || pub_acq;
        flag_clr            = rd_en && (rd_addr == ADDR_FLAGS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    fst_irq_flags #(.N(NUM_FLAGS)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (flag_set),
        .clr_i   (flag_clr),
        .flags_o (flags_q)
    );

    always_comb begin
        status                = '0;
        status[STAT_SYNC_BIT] = sync_q;
        status[STAT_DEC_BIT]  = st_q.dec;
        status[STAT_IDLE_BIT] = st_q.idle;
        case (rd_addr)
            ADDR_STATUS: rd_data = status;
            ADDR_COLOUR: rd_data = 8'(st_q.cc);
            ADDR_FLAGS:  rd_data = 8'(flags_q);
            default:     rd_data = 8'h00;
        endcase
    end

    assign irq = |flags_q;

    a_r4_dec_hold: assert property (@(posedge clk) disable iff (rst)
        !sync_q |=> $stable(st_q.dec));

    a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!sync_q && !sync_det) |=> $stable(st_q.idle));

    a_r8_cc_hold: assert property (@(posedge clk) disable iff (rst)
        !sync_det |=> $stable(st_q.cc));

    a_r8_syncf_with_cc: assert property (@(posedge clk) disable iff (rst)
        sync_det |=> flags_q[FLAG_SYNC]);

    a_r5_idle_change_flagged: assert property (@(posedge clk) disable iff (rst)
        (st_q.idle != $past(st_q.idle)) |-> flags_q[FLAG_IDLE]);
endmodule

// File: tb/fwd_sync_tracker_tb.sv
module fwd_sync_tracker_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_stb = 0, sync_det = 0, bi_vld = 0, bi_bit = 0, bi_last = 0;
    logic dec_vld = 0, dec_fail = 0, rd_en = 0;
    logic [7:0] cc_in = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fwd_sync_tracker dut_i (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .sync_det(sync_det),
        .cc_in(cc_in), .bi_vld(bi_vld), .bi_bit(bi_bit), .bi_last(bi_last),
        .dec_vld(dec_vld), .dec_fail(dec_fail), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic peek(logic [1:0] a, output logic [7:0] v);
        rd_en = 0; rd_addr = a; #1; v = rd_data;
    endtask

    task automatic read_clear(output logic [7:0] v);
        rd_en = 1; rd_addr = 2'd2; #1; v = rd_data;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic strobes(int n);
        for (int i = 0; i < n; i++) begin
            bit_stb = 1; @(negedge clk); bit_stb = 0;
        end
    endtask

    task automatic send_group(logic [4:0] b);
        for (int i = 4; i >= 0; i--) begin
            bit_stb = 1; bi_vld = 1; bi_bit = b[i]; bi_last = (i == 0);
            @(negedge clk);
        end
        bit_stb = 0; bi_vld = 0; bi_bit = 0; bi_last = 0;
    endtask

    task automatic sync_pulse(logic [7:0] cc);
        sync_det = 1; cc_in = cc; @(negedge clk); sync_det = 0;
    endtask

    task automatic dec_report(logic f);
        dec_vld = 1; dec_fail = f; @(negedge clk); dec_vld = 0; dec_fail = 0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        peek(2'd0, v); check("R12 status", v, 8'h00);
        peek(2'd1, v); check("R12 colour", v, 8'h00);
        peek(2'd2, v); check("R12 flags", v, 8'h00);
        check("R12 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_pre_sync_group;
        logic [7:0] v;
        send_group(5'b11101);
        peek(2'd0, v); check("R6 no idle before sync", v, 8'h00);
        peek(2'd2, v); check("R6 no idlef before sync", v, 8'h00);
    endtask

    task automatic t_acquire;
        logic [7:0] v;
        sync_pulse(8'hA5);
        peek(2'd0, v); check("R1/R6 status after acquire", v, 8'hA0);
        peek(2'd1, v); check("R8 colour captured", v, 8'hA5);
        check("R9 irq set", {7'd0, irq}, 8'h01);
        read_clear(v); check("R8 flags on acquire", v, 8'h03);
        peek(2'd2, v); check("R9 flags cleared", v, 8'h00);
        check("R9 irq clear", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_groups;
        logic [7:0] v;
        send_group(5'b00011);
        peek(2'd0, v); check("R3/R5 two ones busy", v, 8'h80);
        read_clear(v); check("R5 idlef set", v, 8'h02);
        send_group(5'b10101);
        peek(2'd0, v); check("R3 three ones idle", v, 8'hA0);
        send_group(5'b01001);
        peek(2'd0, v); check("R3 two ones busy again", v, 8'h80);
        read_clear(v); check("R5 idlef only", v, 8'h02);
    endtask

    task automatic t_decode;
        logic [7:0] v;
        dec_report(1'b1);
        peek(2'd0, v); check("R7 decode fail", v, 8'hC0);
        check("R10 low bits zero", v & 8'h1F, 8'h00);
        dec_report(1'b0);
        peek(2'd0, v); check("R7 decode ok", v, 8'h80);
        peek(2'd3, v); check("R10 addr3 zero", v, 8'h00);
    endtask

    task automatic t_loss;
        logic [7:0] v;
        sync_pulse(8'h3C);
        read_clear(v); check("R8 resync syncf", v, 8'h01);
        strobes(420);
        peek(2'd0, v); check("R2 held at 420", v, 8'h80);
        strobes(1);
        peek(2'd0, v); check("R2 lost at 421", v, 8'h00);
        dec_report(1'b1);
        peek(2'd0, v); check("R4 dec held unsynced", v, 8'h00);
        send_group(5'b11111);
        peek(2'd0, v); check("R4 idle held unsynced", v, 8'h00);
        peek(2'd2, v); check("R4 no idlef unsynced", v, 8'h00);
        sync_pulse(8'h5A);
        peek(2'd0, v); check("R6 reacquire publishes", v, 8'hA0);
        peek(2'd2, v); check("R6 idlef on reacquire", v, 8'h03);
    endtask

    task automatic t_cc_hold;
        logic [7:0] v;
        cc_in = 8'hFF;
        strobes(3);
        peek(2'd1, v); check("R8 colour held", v, 8'h5A);
    endtask

    task automatic t_race;
        logic [7:0] v;
        rd_en = 1; rd_addr = 2'd2; sync_det = 1; cc_in = 8'h77;
        @(negedge clk);
        rd_en = 0; sync_det = 0;
        peek(2'd2, v); check("R11 syncf survives read", v, 8'h01);
        peek(2'd1, v); check("R8 colour on race", v, 8'h77);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset;
        t_pre_sync_group;
        t_acquire;
        t_groups;
        t_decode;
        t_loss;
        t_cc_hold;
        t_race;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule